// File: doc/BRIEF.md
# Oversampled Channel Result Interface

This block holds the control state and the result of one conversion channel that sits behind a decimation filter. The filter delivers a wide two's-complement word with a one-cycle valid strobe. The block decides whether that word is kept, converts it to the selected number format and stores it. It then presents the stored word through a 16-bit read window that shows either the upper or the lower half.

Software drives the block through a small register port. Register 0 holds the control word, register 1 holds the first-result delay code, and register 2 is the result window. The block has two conversion modes. In continuous mode every sample is kept while the start bit stays set. In single mode exactly one result is kept per start. After each start, a programmable number of leading samples is discarded so that the first stored result comes from a settled filter. A ready flag and an overflow flag, combined with the interrupt enable, go to the interrupt vector logic. A group chain output passes this channel's start on to the next higher channel. The block also decodes the oversampling selection into a ratio for the filter.

Top module: `ovs_result_port`

## Requirements
- R1: After a synchronous active-low reset, the control word and the delay code read 0, the ready, overflow, interrupt and chain outputs are low, and the decoded ratio is 256.
- R2: Control bit 6 (half select) chooses the result window. With bit 6 at 0, a read of register 2 returns bits 31:16 of the stored result. With bit 6 at 1, it returns bits 15:0.
- R3: When control bit 7 (toggle enable) is 1, every read of register 2 inverts control bit 6.
- R4: The ready flag (control bit 3, `rdy_o`) sets when a result is stored. It clears when register 2 is read. It also clears when software writes the control word with bit 3 at 0; writing 1 to bit 3 leaves the flag unchanged.
- R5: The overflow flag (control bit 4, `ovf_o`) sets when a result is stored while the ready flag is set and register 2 is not being read in that cycle. A read of register 2 does not clear it. Only a control write with bit 4 at 0 clears it.
- R6: Register 1 bits 1:0 select which valid sample after a start is stored first: 00 selects the fourth, 01 the third, 10 the second and 11 the first. Samples before the selected one are discarded and do not set the ready flag.
- R7: With control bit 11 (single mode) at 1, the start bit (bit 0) clears itself in the cycle that stores the result. Later samples are not stored until software sets the start bit again.
- R8: With control bit 11 at 0, every valid sample after the delay is stored for as long as the channel runs. While the start bit and `chain_start_i` are both low, no sample is stored and the result does not change.
- R9: Control bit 5 selects the data format. At 1, the filter word is stored unchanged (two's complement). At 0, it is stored with its most significant bit inverted (offset binary).
- R10: `ratio_o` reports the oversampling ratio. With control bit 10 at 0, bits 9:8 encode 00=256, 01=128, 10=64 and 11=32. With bit 10 at 1, 00=512 and 01=1024, and the reserved codes 10 and 11 give 0.
- R11: `chain_start_o` equals group bit 1 AND start bit 0, and it is tied low when `IS_LAST` is 1. A high `chain_start_i` runs the channel exactly as a set start bit does.
- R12: `irq_o` is high exactly when the ready flag and the interrupt enable (control bit 2) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on register 2) |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 delay code, 2 result window |
| reg_wdata | input | WIN_W | Write data |
| reg_rdata | output | WIN_W | Read data for the addressed register |
| flt_data | input | RES_W | Filter output word, two's complement |
| flt_valid | input | 1 | One-cycle strobe marking a new filter word |
| chain_start_i | input | 1 | Start from the grouped lower channel |
| chain_start_o | output | 1 | Start passed to the next higher channel |
| ratio_o | output | RATIO_W | Decoded oversampling ratio, 0 for reserved codes |
| rdy_o | output | 1 | Ready flag |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Ready interrupt request |

## Verification
The hardest situation to reach is the discard window after a start. It is only visible when the delay code, the mode and the number of valid strobes are all lined up correctly. The stimulus programs code 00 in single mode and delivers four distinct samples, checking after each one that the ready flag stays low until the fourth. It then confirms that the start bit has cleared and that a fifth sample is ignored. Overflow is reached by delivering two samples back to back without an intervening read, and then reading the result to show that the flag stays set.

// File: rtl/ovs_pkg.sv
// Package: register addresses and control-word bit positions shared by the
// result port and its bench-facing documentation. Assumes a 12-bit control word.
package ovs_pkg;
    localparam int ADR_CTL = 0;
    localparam int ADR_DLY = 1;
    localparam int ADR_RES = 2;

    localparam int B_START = 0;
    localparam int B_GROUP = 1;
    localparam int B_IE    = 2;
    localparam int B_RDY   = 3;
    localparam int B_OVF   = 4;
    localparam int B_TWOS  = 5;
    localparam int B_HALF  = 6;
    localparam int B_TOG   = 7;
    localparam int B_OSR   = 8;   // two bits, 9:8
    localparam int B_EXT   = 10;
    localparam int B_SNGL  = 11;
    localparam int CTL_W   = 12;
    localparam int DLY_W   = 2;
endpackage

// File: rtl/ovs_ratio_decode.sv
// Module: decodes the oversampling code and extension bit into a ratio value.
// Assumes RATIO_W is wide enough to hold 1024; reserved codes give 0.
module ovs_ratio_decode #(
    parameter int RATIO_W = 11
) (
    input  logic [1:0]         code_i,
    input  logic               ext_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam logic [RATIO_W-1:0] BASE_RATIO = RATIO_W'(256);

    // Ratio selection: halve the base per code step, or pick an extended value.
    always_comb begin
        if (!ext_i) begin
            ratio_o = BASE_RATIO >> code_i;
        end else begin
            case (code_i)
                2'd0:    ratio_o = BASE_RATIO << 1;
                2'd1:    ratio_o = BASE_RATIO << 2;
                default: ratio_o = '0;
            endcase
        end
    end

    // R10: a decoded ratio is a power of two or zero
    always_comb begin
        a_ratio_pow2_r10: assert ($countones(ratio_o) <= 1);
    end
endmodule

// File: rtl/ovs_delay_gate.sv
// Module: counts valid samples after a start and passes a sample on only once
// the programmed number of leading samples has been discarded. The counter
// reloads from the delay code whenever the channel is idle.
module ovs_delay_gate #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             valid_i,
    input  logic [DLY_W-1:0] dly_code_i,
    output logic             accept_o
);
    logic [DLY_W-1:0] skip_q;

    // Skip counter: reload while idle, count down on discarded samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= '0;
        end else if (!run_i) begin
            skip_q <= ~dly_code_i;
        end else if (valid_i && skip_q != '0) begin
            skip_q <= skip_q - 1'b1;
        end
    end

    assign accept_o = run_i && valid_i && (skip_q == '0);

    // R8: nothing is accepted while the channel is idle
    p_idle_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !accept_o);
    // R6: a discarded sample is never accepted in the cycle after a reload
    p_reload_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && dly_code_i != {DLY_W{1'b1}}) |=> !(accept_o && $past(!run_i)));
endmodule

// File: rtl/ovs_result_hold.sv
// Module: stores the formatted result and serves one half of it through the
// read window; owns the half-select bit and its toggle-on-read behaviour.
// Assumes RES_W is exactly twice WIN_W.
module ovs_result_hold #(
    parameter int RES_W = 32,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_i,
    input  logic             twos_i,
    input  logic [RES_W-1:0] data_i,
    input  logic             half_wr_i,
    input  logic             half_wdata_i,
    input  logic             rd_i,
    input  logic             tog_i,
    output logic             half_o,
    output logic [WIN_W-1:0] window_o
);
    localparam int MSB = RES_W - 1;

    logic [RES_W-1:0] res_q;
    logic             half_q;

    // Result register: keep two's complement or flip the sign bit for offset binary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (store_i) begin
            res_q <= twos_i ? data_i : {~data_i[MSB], data_i[MSB-1:0]};
        end
    end

    // Half select: software write, then toggle on a window read if enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (rd_i && tog_i) begin
            half_q <= ~half_q;
        end else if (half_wr_i) begin
            half_q <= half_wdata_i;
        end
    end

    assign half_o   = half_q;
    assign window_o = half_q ? res_q[WIN_W-1:0] : res_q[MSB -: WIN_W];

    // R3: a read with toggle enabled inverts the half select
    p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && tog_i) |=> (half_q != $past(half_q)));
    // R2: without a write or a toggling read the half select holds
    p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_wr_i && !(rd_i && tog_i)) |=> $stable(half_q));
    // R8: the stored result changes only on a store
    p_res_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !store_i |=> $stable(res_q));
endmodule

// File: rtl/ovs_result_port.sv
// Module: per-channel control and result interface behind a decimation filter.
// Holds the control word and delay code, runs single or continuous conversion,
// maintains ready/overflow flags and the group start chain. Assumes register
// reads are combinational and their side effects take place at the clock edge.
module ovs_result_port
    import ovs_pkg::*;
#(
    parameter int RES_W   = 32,
    parameter int WIN_W   = 16,
    parameter int ADDR_W  = 2,
    parameter int RATIO_W = 11,
    parameter bit IS_LAST = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WIN_W-1:0]   reg_wdata,
    output logic [WIN_W-1:0]   reg_rdata,
    input  logic [RES_W-1:0]   flt_data,
    input  logic               flt_valid,
    input  logic               chain_start_i,
    output logic               chain_start_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               rdy_o,
    output logic               ovf_o,
    output logic               irq_o
);
    logic             start_q, group_q, ie_q, rdy_q, ovf_q, twos_q, tog_q, ext_q, sngl_q;
    logic [1:0]       osr_q;
    logic [DLY_W-1:0] dly_q;
    logic             half;
    logic [WIN_W-1:0] window;
    logic             wr_ctl, wr_dly, rd_res, running, accept;
    logic [CTL_W-1:0] ctl_word;
    logic             unused_wdata;

    assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(ADR_CTL));
    assign wr_dly  = reg_wr && (reg_addr == ADDR_W'(ADR_DLY));
    assign rd_res  = reg_rd && (reg_addr == ADDR_W'(ADR_RES));
    assign running = start_q || chain_start_i;
    assign unused_wdata = ^reg_wdata[WIN_W-1:CTL_W];

    // Control fields and flags: software writes, then read and store effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {start_q, group_q, ie_q, rdy_q, ovf_q, twos_q, tog_q, ext_q, sngl_q} <= '0;
            osr_q <= '0;
            dly_q <= '0;
        end else begin
            if (wr_ctl) begin
                start_q <= reg_wdata[B_START];
                group_q <= reg_wdata[B_GROUP];
                ie_q    <= reg_wdata[B_IE];
                twos_q  <= reg_wdata[B_TWOS];
                tog_q   <= reg_wdata[B_TOG];
                osr_q   <= reg_wdata[B_OSR +: 2];
                ext_q   <= reg_wdata[B_EXT];
                sngl_q  <= reg_wdata[B_SNGL];
                rdy_q   <= rdy_q & reg_wdata[B_RDY];
                ovf_q   <= ovf_q & reg_wdata[B_OVF];
            end
            if (wr_dly) begin
                dly_q <= reg_wdata[DLY_W-1:0];
            end
            if (rd_res) begin
                rdy_q <= 1'b0;
            end
            if (accept) begin
                rdy_q <= 1'b1;
                if (rdy_q && !rd_res) ovf_q <= 1'b1;
                if (sngl_q) start_q <= 1'b0;
            end
        end
    end

    ovs_delay_gate #(.DLY_W(DLY_W)) i_gate (
        .clk(clk), .rst_n(rst_n), .run_i(running), .valid_i(flt_valid),
        .dly_code_i(dly_q), .accept_o(accept)
    );

    ovs_result_hold #(.RES_W(RES_W), .WIN_W(WIN_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .store_i(accept), .twos_i(twos_q), .data_i(flt_data),
        .half_wr_i(wr_ctl), .half_wdata_i(reg_wdata[B_HALF]), .rd_i(rd_res), .tog_i(tog_q),
        .half_o(half), .window_o(window)
    );

    ovs_ratio_decode #(.RATIO_W(RATIO_W)) i_ratio (
        .code_i(osr_q), .ext_i(ext_q), .ratio_o(ratio_o)
    );

    // Control word image for reads.
    always_comb begin
        ctl_word            = '0;
        ctl_word[B_START]   = start_q;
        ctl_word[B_GROUP]   = group_q;
        ctl_word[B_IE]      = ie_q;
        ctl_word[B_RDY]     = rdy_q;
        ctl_word[B_OVF]     = ovf_q;
        ctl_word[B_TWOS]    = twos_q;
        ctl_word[B_HALF]    = half;
        ctl_word[B_TOG]     = tog_q;
        ctl_word[B_OSR +: 2] = osr_q;
        ctl_word[B_EXT]     = ext_q;
        ctl_word[B_SNGL]    = sngl_q;
    end

    // Read multiplexer over the three registers.
    always_comb begin
        if (reg_addr == ADDR_W'(ADR_CTL))      reg_rdata = WIN_W'(ctl_word);
        else if (reg_addr == ADDR_W'(ADR_DLY)) reg_rdata = WIN_W'(dly_q);
        else if (reg_addr == ADDR_W'(ADR_RES)) reg_rdata = window;
        else                                   reg_rdata = '0;
    end

    // Group chain: the last channel never forwards its start.
    generate
        if (IS_LAST) begin : g_last
            assign chain_start_o = 1'b0;
        end else begin : g_chain
            assign chain_start_o = group_q && start_q;
        end
    endgenerate

    assign rdy_o = rdy_q;
    assign ovf_o = ovf_q;
    assign irq_o = rdy_q && ie_q;

    // R4: a store always leaves the ready flag set
    p_rdy_on_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rdy_q);
    // R5: overflow survives anything but a clearing control write
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_ctl && !reg_wdata[B_OVF])) |=> ovf_q);
    // R5: store on a still-ready result raises overflow
    p_ovf_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rdy_q && !rd_res) |=> ovf_q);
    // R7: single mode stops after its stored result
    p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sngl_q) |=> !start_q);
    // R12: the interrupt request never stands without the ready flag
    p_irq_needs_rdy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rdy_o);
endmodule

// File: tb/test_ovs_result_port.sv
`timescale 1ns/100ps
module test_ovs_result_port;
    localparam int RES_W = 32, WIN_W = 16, ADDR_W = 2, RATIO_W = 11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [WIN_W-1:0]   reg_wdata = '0;
    logic [WIN_W-1:0]   reg_rdata, l_rdata;
    logic [RES_W-1:0]   flt_data = '0;
    logic               flt_valid = 1'b0, chain_start_i = 1'b0;
    logic               chain_start_o, l_chain;
    logic [RATIO_W-1:0] ratio_o, l_ratio;
    logic               rdy_o, ovf_o, irq_o, l_rdy, l_ovf, l_irq;

    int n_cmp = 0, n_bad = 0;
    logic [WIN_W-1:0] exp_q[$];
    string            tag_q[$];

    always #2 clk = ~clk;

    ovs_result_port #(.RES_W(RES_W), .WIN_W(WIN_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W))
    i_ovs_result_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_data(flt_data), .flt_valid(flt_valid),
        .chain_start_i(chain_start_i), .chain_start_o(chain_start_o), .ratio_o(ratio_o),
        .rdy_o(rdy_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    ovs_result_port #(.RES_W(RES_W), .WIN_W(WIN_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W),
                      .IS_LAST(1'b1))
    i_last (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(l_rdata), .flt_data(flt_data), .flt_valid(flt_valid),
        .chain_start_i(chain_start_i), .chain_start_o(l_chain), .ratio_o(l_ratio),
        .rdy_o(l_rdy), .ovf_o(l_ovf), .irq_o(l_irq)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [WIN_W-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    // Driver: queue the expected window word, then issue the read.
    task automatic rd_res(input logic [WIN_W-1:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = ADDR_W'(2);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic sample(input logic [RES_W-1:0] d);
        @(posedge clk); #1;
        flt_data = d; flt_valid = 1'b1;
        @(posedge clk); #1;
        flt_valid = 1'b0;
    endtask

    task automatic get_ctl(output logic [WIN_W-1:0] v);
        @(posedge clk); #1;
        reg_addr = ADDR_W'(0);
        @(negedge clk);
        v = reg_rdata;
    endtask

    // Monitor: compare every result-window read against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && reg_rd && reg_addr == ADDR_W'(2)) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read: got %0h expected none", reg_rdata);
            end else begin
                automatic logic [WIN_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(32'(reg_rdata), 32'(e), t);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [WIN_W-1:0] c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(32'(rdy_o), 0, "R1 ready");
        check(32'(ovf_o), 0, "R1 overflow");
        check(32'(irq_o), 0, "R1 irq");
        check(32'(chain_start_o), 0, "R1 chain");
        check(32'(ratio_o), 256, "R1 ratio");
        get_ctl(c);
        check(32'(c), 0, "R1 control");

        // First-sample delay, two's complement, halves.
        wr(1, 16'h0003);
        wr(0, 16'h0025);
        sample(32'h8001_1234);
        @(negedge clk);
        check(32'(rdy_o), 1, "R4 ready set");
        check(32'(irq_o), 1, "R12 irq with enable");
        rd_res(16'h8001, "R2 upper half / R9 twos");
        @(negedge clk);
        check(32'(rdy_o), 0, "R4 cleared by read");
        wr(0, 16'h0065);
        rd_res(16'h1234, "R2 lower half");

        // Continuous: two samples, no read -> overflow.
        sample(32'h1111_2222);
        sample(32'h3333_4444);
        @(negedge clk);
        check(32'(ovf_o), 1, "R5 overflow set");
        rd_res(16'h4444, "R8 continuous keeps latest");
        @(negedge clk);
        check(32'(rdy_o), 0, "R4 ready cleared");
        check(32'(ovf_o), 1, "R5 read keeps overflow");
        wr(0, 16'h0025);
        @(negedge clk);
        check(32'(ovf_o), 0, "R5 write clears overflow");

        // Offset binary.
        wr(0, 16'h0005);
        sample(32'h8001_0000);
        rd_res(16'h0001, "R9 offset binary msb set");
        sample(32'h1234_5678);
        rd_res(16'h9234, "R9 offset binary msb clear");

        // Stopped channel ignores samples.
        wr(0, 16'h0004);
        sample(32'hFFFF_FFFF);
        @(negedge clk);
        check(32'(rdy_o), 0, "R8 stopped no ready");
        rd_res(16'h9234, "R8 stopped result unchanged");

        // Fourth-sample delay, single mode.
        wr(1, 16'h0000);
        wr(0, 16'h0821);
        sample(32'h0101_0000);
        sample(32'h0202_0000);
        sample(32'h0303_0000);
        @(negedge clk);
        check(32'(rdy_o), 0, "R6 three samples discarded");
        sample(32'h0404_0000);
        @(negedge clk);
        check(32'(rdy_o), 1, "R6 fourth sample stored");
        get_ctl(c);
        check(32'(c[0]), 0, "R7 start self-cleared");
        rd_res(16'h0404, "R6 fourth sample value");
        sample(32'h0505_0000);
        @(negedge clk);
        check(32'(rdy_o), 0, "R7 one result per start");

        // Second-sample delay.
        wr(1, 16'h0002);
        wr(0, 16'h0821);
        sample(32'h0A0A_0000);
        @(negedge clk);
        check(32'(rdy_o), 0, "R6 code 10 discards first");
        sample(32'h0B0B_0000);
        rd_res(16'h0B0B, "R6 code 10 second stored");

        // Toggle on read.
        wr(1, 16'h0003);
        wr(0, 16'h00A1);
        sample(32'hAAAA_5555);
        rd_res(16'hAAAA, "R3 toggle read 1");
        rd_res(16'h5555, "R3 toggle read 2");
        rd_res(16'hAAAA, "R3 toggle read 3");
        get_ctl(c);
        check(32'(c[6]), 1, "R3 half bit after three reads");

        // Software clear of ready.
        sample(32'h0000_0001);
        @(negedge clk);
        check(32'(rdy_o), 1, "R4 ready before clear");
        wr(0, 16'h00A1);
        @(negedge clk);
        check(32'(rdy_o), 0, "R4 write clears ready");

        // Ratio decode.
        for (int k = 0; k < 4; k++) begin
            wr(0, 16'(k << 8));
            @(negedge clk);
            check(32'(ratio_o), 32'(256 >> k), "R10 normal ratio");
        end
        wr(0, 16'h0400);
        @(negedge clk);
        check(32'(ratio_o), 512, "R10 extended 512");
        wr(0, 16'h0500);
        @(negedge clk);
        check(32'(ratio_o), 1024, "R10 extended 1024");
        wr(0, 16'h0600);
        @(negedge clk);
        check(32'(ratio_o), 0, "R10 reserved code");

        // Group chain.
        wr(0, 16'h0003);
        @(negedge clk);
        check(32'(chain_start_o), 1, "R11 group and start");
        check(32'(l_chain), 0, "R11 last channel no chain");
        wr(0, 16'h0002);
        @(negedge clk);
        check(32'(chain_start_o), 0, "R11 group without start");
        wr(0, 16'h0000);
        @(posedge clk); #1 chain_start_i = 1'b1;
        sample(32'h7777_0000);
        @(negedge clk);
        check(32'(rdy_o), 1, "R11 chain input runs channel");
        check(32'(irq_o), 0, "R12 no irq without enable");
        rd_res(16'hF777, "R11 chained result offset");
        @(posedge clk); #1 chain_start_i = 1'b0;

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule